// File: doc/BRIEF.md
# Three-wire serial EEPROM shift engine

This block moves between 0 and 8 bits over a three-wire serial EEPROM bus: a clock it generates, one bidirectional data line, and a chip select. The chip select is not part of this block; a general-purpose pin raises it before a transfer and lowers it afterwards. Software loads an 8-bit data register and then writes a control byte. Writing the control byte starts the command. The control byte gives the bit count, the direction, whether the data driver is released after the last clock, and whether completion should wait for the EEPROM to signal ready.

While a command runs, the block drives the serial clock at a fixed fraction of the system clock. It shifts bits out of the top of the data register, or shifts sampled bits into its bottom, and it controls the output enable of the data line. A busy flag covers the whole command. A one-cycle interrupt marks the cycle in which busy falls. Software typically uses a command with a count of zero to drive the line low-impedance again once a read has finished.

Top module: `ser3w_engine`

## Requirements
- R1: A write with `reg_addr`=0 while idle starts a command, and `busy` is high from the next cycle. The control byte fields are: bit 6 wait-for-ready, bit 5 release (high impedance), bit 4 read, bits 3:0 count. `reg_addr`=1 writes the data register.
- R2: With read=0, bits are sent most-significant first from bit 7 of the data register. The line is driven (`sd_oe`=1) and `sd_out` is stable while `sclk` is low before each rising edge.
- R3: A command issues exactly as many rising `sclk` edges as the count field. Counts above 8 are treated as 8.
- R4: With read=1, `sd_in` is sampled on each rising `sclk` edge and shifted in at bit 0. After N bits, bits N-1:0 of `data_q` hold the bits read, the first one in the highest of those positions. `sd_oe` is 0 while `sclk` is high during a read.
- R5: At the end of a transfer with a nonzero count, `sd_oe` becomes the inverse of the release bit. For a write this happens at the final rising edge. For a read it happens when the final clock high phase ends.
- R6: With count 0, no clock edges occur, `sd_oe` becomes the inverse of the release bit, and the command completes.
- R7: With wait-for-ready=1 and release=1, `busy` stays high after the last clock until a rising edge is seen on `sd_in`. With release=0, wait-for-ready has no effect.
- R8: `irq` is high for exactly one cycle, and only in the cycle where `busy` has just fallen.
- R9: Control and data register writes that arrive while `busy` is high are ignored.
- R10: After reset, `busy`, `irq`, `sclk`, `sd_oe` and `data_q` are all 0.
- R11: Successive rising `sclk` edges in one command are 2*HALF_DIV system clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control byte, 1 = data register |
| reg_wdata | input | 8 | Register write data |
| busy | output | 1 | Command in progress |
| data_q | output | 8 | Data register contents |
| sclk | output | 1 | Serial clock to the EEPROM |
| sd_out | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_in | input | 1 | Data line input value |
| irq | output | 1 | Completion pulse |

## Verification
The completion of a command, where `busy` falls and `irq` pulses, can land in the same cycle as a new control write. The bench provokes this by watching for `sclk` to drop after the last edge of a one-bit write. It then presents a control write at exactly that point, so the write is sampled on the edge that retires the command. The write is judged ignored if `busy` stays low and no `sclk` edge appears in the cycles after the interrupt. The scoreboard also confirms that the retiring command still delivered its single bit and its final output-enable state.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
  localparam int REG_W = 8;
  localparam int CNT_W = 4;
  localparam int BIT_WFR = 6;
  localparam int BIT_REL = 5;
  localparam int BIT_RD  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_WAIT,
    ST_FIN
  } ser3w_state_e;

  typedef struct packed {
    logic             wfr;
    logic             rel;
    logic             rd;
    logic [CNT_W-1:0] cnt;
  } ser3w_cmd_t;
endpackage

// File: rtl/ser3w_tick.sv
module ser3w_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ser3w_shreg.sv
module ser3w_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_in,
  input  logic         shift_out,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (load)      q <= load_val;
    else if (shift_in)  q <= {q[W-2:0], sin};
    else if (shift_out) q <= {q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/ser3w_engine.sv
module ser3w_engine
  import ser3w_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             busy,
  output logic [REG_W-1:0] data_q,
  output logic             sclk,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in,
  output logic             irq
);
  ser3w_state_e     state_q;
  ser3w_cmd_t       cmd_q;
  logic [CNT_W-1:0] rem_q;
  logic             sd_in_q;
  logic             tick;
  logic             ctrl_wr, data_wr;
  logic [CNT_W-1:0] cnt_req, cnt_clamped;
  logic             wait_mode;
  logic             last_bit;
  logic             cmd_rd_w;
  logic [CNT_W-1:0] cmd_cnt_w;

  assign ctrl_wr     = reg_we && !reg_addr && !busy;
  assign data_wr     = reg_we &&  reg_addr && !busy;
  assign cnt_req     = reg_wdata[CNT_W-1:0];
  assign cnt_clamped = (cnt_req > CNT_W'(REG_W)) ? CNT_W'(REG_W) : cnt_req;
  assign wait_mode   = cmd_q.wfr && cmd_q.rel;
  assign last_bit    = (rem_q == CNT_W'(1));
  assign cmd_rd_w    = cmd_q.rd;
  assign cmd_cnt_w   = cmd_q.cnt;

  ser3w_tick #(.HALF_DIV(HALF_DIV)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .run  ((state_q == ST_LOW) || (state_q == ST_HIGH)),
    .tick (tick)
  );

  ser3w_shreg #(.W(REG_W)) shreg_i (
    .clk       (clk),
    .rst       (rst),
    .load      (data_wr),
    .load_val  (reg_wdata),
    .shift_in  ((state_q == ST_LOW) && tick && cmd_q.rd),
    .shift_out ((state_q == ST_HIGH) && tick && !cmd_q.rd),
    .sin       (sd_in),
    .q         (data_q)
  );

  assign sd_out = data_q[REG_W-1];

  always_ff @(posedge clk) begin
    if (rst) sd_in_q <= 1'b0;
    else     sd_in_q <= sd_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      rem_q   <= '0;
      busy    <= 1'b0;
      irq     <= 1'b0;
      sclk    <= 1'b0;
      sd_oe   <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ctrl_wr) begin
            cmd_q.wfr <= reg_wdata[BIT_WFR];
            cmd_q.rel <= reg_wdata[BIT_REL];
            cmd_q.rd  <= reg_wdata[BIT_RD];
            cmd_q.cnt <= cnt_clamped;
            rem_q     <= cnt_clamped;
            busy      <= 1'b1;
            if (cnt_clamped == '0) begin
              sd_oe   <= !reg_wdata[BIT_REL];
              state_q <= (reg_wdata[BIT_REL] && reg_wdata[BIT_WFR]) ? ST_WAIT : ST_FIN;
            end else begin
              sd_oe   <= !reg_wdata[BIT_RD];
              state_q <= ST_LOW;
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk    <= 1'b1;
            state_q <= ST_HIGH;
            if (last_bit && !cmd_q.rd) sd_oe <= !cmd_q.rel;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk  <= 1'b0;
            rem_q <= rem_q - 1'b1;
            if (last_bit) begin
              if (cmd_q.rd) sd_oe <= !cmd_q.rel;
              state_q <= wait_mode ? ST_WAIT : ST_FIN;
            end else begin
              state_q <= ST_LOW;
            end
          end
        end
        ST_WAIT: begin
          if (sd_in && !sd_in_q) state_q <= ST_FIN;
        end
        ST_FIN: begin
          busy    <= 1'b0;
          irq     <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ser3w_engine_chk.sv
module ser3w_engine_chk
  import ser3w_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             irq,
  input logic             sclk,
  input logic             sd_oe,
  input logic             reg_we,
  input logic             reg_addr,
  input logic             cmd_rd,
  input logic [CNT_W-1:0] cmd_cnt
);
  AST_IRQ_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq); // R8
  AST_IRQ_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst)
    irq |-> $fell(busy)); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R8
  AST_SCLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    sclk |-> busy); // R3
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (sclk && cmd_rd) |-> !sd_oe); // R4
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && !reg_addr) |=> $stable(cmd_cnt)); // R9
  AST_CNT_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    cmd_cnt <= CNT_W'(REG_W)); // R3
endmodule

bind ser3w_engine ser3w_engine_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .irq      (irq),
  .sclk     (sclk),
  .sd_oe    (sd_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .cmd_rd   (cmd_rd_w),
  .cmd_cnt  (cmd_cnt_w)
);

// File: tb/ser3w_engine_tb_top.sv
module ser3w_engine_tb_top;
  localparam int HALF_DIV = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       busy, sclk, sd_out, sd_oe, irq;
  logic [7:0] data_q;
  logic       sd_in_r = 1'b0;

  always #2 clk = ~clk;

  ser3w_engine #(.HALF_DIV(HALF_DIV)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .data_q(data_q), .sclk(sclk),
    .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in_r), .irq(irq)
  );

  typedef struct packed {
    int         edges;
    logic       is_rd;
    logic [7:0] wbits;
    logic       oe_end;
    logic [7:0] dexp;
    logic [7:0] dmask;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;

  logic       cur_rd = 1'b0;
  logic [7:0] rd_pat = 8'h00;
  int         rd_n = 0;
  logic       wait_line = 1'b0;

  int         edges = 0;
  logic [7:0] wcap = 8'h00;
  logic       sclk_prev = 1'b0, out_prev = 1'b0, oe_prev = 1'b0;
  int         cyc = 0, last_rise = 0;

  task automatic check(input string req, input logic ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor and scoreboard
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (sclk && !sclk_prev) begin
        edges++;
        if (cur_rd) check("R4 released at rise", !sd_oe, sd_oe, 0);
        else begin
          wcap = {wcap[6:0], out_prev};
          check("R2 driven before rise", oe_prev, oe_prev, 1);
        end
        if (edges > 1) check("R11 clock period", (cyc - last_rise) == 2*HALF_DIV,
                             cyc - last_rise, 2*HALF_DIV);
        last_rise = cyc;
      end
      if (irq) begin
        if (exp_q.size() == 0) check("R8 unexpected irq", 1'b0, 1, 0);
        else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " R3 edge count"}, edges == e.edges, edges, e.edges);
          check({t, " R5 final oe"}, sd_oe == e.oe_end, sd_oe, e.oe_end);
          if (e.is_rd)
            check({t, " R4 read data"}, (data_q & e.dmask) == e.dexp, data_q & e.dmask, e.dexp);
          else
            check({t, " R2 bits sent"}, (wcap & e.dmask) == e.wbits, wcap & e.dmask, e.wbits);
        end
        edges = 0;
        wcap = 8'h00;
      end
      if (cur_rd && edges < rd_n) sd_in_r = rd_pat[rd_n-1-edges];
      else                        sd_in_r = wait_line;
    end
    sclk_prev = sclk;
    out_prev  = sd_out;
    oe_prev   = sd_oe;
  end

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push_exp(input string t, input logic [7:0] ctrl, input logic [7:0] d,
                          input logic [7:0] pat);
    exp_t e;
    int   n;
    n = (ctrl[3:0] > 8) ? 8 : int'(ctrl[3:0]);
    e.edges  = n;
    e.is_rd  = ctrl[4];
    e.oe_end = !ctrl[5];
    e.dmask  = (n == 8) ? 8'hFF : 8'((1 << n) - 1);
    e.dexp   = pat & e.dmask;
    e.wbits  = (n == 0) ? 8'h00 : 8'(d >> (8 - n));
    exp_q.push_back(e);
    tag_q.push_back(t);
    cur_rd = ctrl[4];
    rd_pat = pat;
    rd_n   = n;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_cmd(input string t, input logic [7:0] ctrl, input logic [7:0] d,
                         input logic [7:0] pat);
    reg_write(1'b1, d);
    push_exp(t, ctrl, d, pat);
    reg_write(1'b0, ctrl);
    check({t, " R1 busy after start"}, busy, busy, 1);
    wait_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 1'b0, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset outputs", {busy, irq, sclk, sd_oe} == 4'b0, {busy, irq, sclk, sd_oe}, 0);
    check("R10 reset data", data_q == 8'h00, data_q, 0);

    run_cmd("write8",  8'h08, 8'hA7, 8'h00);
    run_cmd("write5 rel", 8'h25, 8'h5C, 8'h00);
    run_cmd("read8",   8'h18, 8'h00, 8'h96);
    run_cmd("read3 rel", 8'h33, 8'hF0, 8'h05);
    run_cmd("R3 clamp", 8'h0F, 8'hC3, 8'h00);
    run_cmd("R6 cnt0 drive", 8'h00, 8'h11, 8'h00);
    run_cmd("R6 cnt0 release", 8'h20, 8'h11, 8'h00);
    run_cmd("R7 wfr ignored", 8'h41, 8'h80, 8'h00);

    // R7: wait-for-ready with release set
    wait_line = 1'b0;
    reg_write(1'b1, 8'hB0);
    push_exp("R7 wait", 8'h62, 8'hB0, 8'h00);
    reg_write(1'b0, 8'h62);
    repeat (40) @(negedge clk);
    check("R7 busy held", busy, busy, 1);
    wait_line = 1'b1;
    wait_done();
    check("R7 finished", !busy, busy, 0);
    wait_line = 1'b0;
    repeat (2) @(negedge clk);

    // R9: writes during a read are ignored
    reg_write(1'b1, 8'h00);
    push_exp("R9 busy writes", 8'h18, 8'h00, 8'hA5);
    reg_write(1'b0, 8'h18);
    while (edges < 3) @(negedge clk);
    reg_write(1'b1, 8'hFF);
    reg_write(1'b0, 8'h08);
    wait_done();

    // R9: control write landing on the completion edge
    begin
      logic seen;
      seen = 1'b0;
      reg_write(1'b1, 8'h80);
      push_exp("R9 collide", 8'h01, 8'h80, 8'h00);
      reg_write(1'b0, 8'h01);
      while (!(seen && !sclk)) begin
        if (sclk) seen = 1'b1;
        @(negedge clk);
      end
      reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h03;
      @(negedge clk);
      reg_we = 1'b0;
      check("R8 irq at completion", irq, irq, 1);
      begin
        int bad;
        bad = 0;
        repeat (12) begin
          @(negedge clk);
          if (busy || sclk) bad++;
        end
        check("R9 collide write ignored", bad == 0, bad, 0);
      end
    end

    repeat (4) @(negedge clk);
    check("R8 all completions seen", exp_q.size() == 0, exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule